// File: doc/BRIEF.md
# Fractional-N Pulse-Swallow Feedback Divider

This block forms the feedback divide path of a fractional-N frequency synthesizer. It is clocked by the output of an external dual-modulus prescaler and drives that prescaler's modulus-select line. Each division period spans M prescaler output cycles. During the first S of them the block asks the prescaler for the larger modulus (P+1), and during the rest for the smaller one (P). At the last cycle of the period it emits a one-cycle pulse for the phase detector. S is the swallow count A, plus one extra cycle on the periods where a 5-bit fraction accumulator overflows. The accumulator adds F every period, modulo 32. Averaged over many periods, the input-to-output ratio is P·M + A + F/32.

The prescaler width is a parameter. `P_LOG2 = 5` is for a 32/33 prescaler and gives a 5-bit A. `P_LOG2 = 4` is for a 16/17 prescaler and gives a 4-bit A. The legal inputs are 3 < M < 511, A < M with A below 2^P_LOG2 − 1, and F < 31. Because the accumulator works modulo 32, an even F repeats on a shorter cycle. For example, F = 12 gives 3 extra cycles every 8 periods.

The controller has three states:
- `ST_LOAD` is held during reset. On the first clock edge after reset it captures the configuration and moves to the first counting state.
- `ST_SWALLOW` drives the modulus request high. It moves to `ST_MAIN` once S cycles have been counted.
- `ST_MAIN` holds the request low.

At the last cycle of a period, the boundary transition leaves either counting state. It reloads M, A and F, steps the accumulator, and re-enters `ST_SWALLOW` when the new S is non-zero, or `ST_MAIN` when it is zero.

Top module: `fracn_swallow_div`

## Requirements
- R1: While reset is low, `mod_hi` and `div_pulse` are low and the accumulator is cleared to zero. So the first period after reset gets no extra cycle for any legal F, and with F = 16 the second period does get one.
- R2: Consecutive `div_pulse` assertions are exactly M cycles apart. The pulse is high for one cycle, the last cycle of the period.
- R3: In each period `mod_hi` is high for exactly the first S cycles and low for the rest, where S = A + c.
- R4: c is the carry out of the 5-bit sum of the accumulator and F. The accumulator keeps that sum modulo 32. Over any 32 consecutive periods with constant F, the c values add up to F.
- R5: An even F gives a shorter repetition. F = 16 adds 1 extra cycle per 2 periods, F = 8 adds 1 per 4, F = 24 adds 3 per 4, and F = 12 adds 3 per 8.
- R6: M, A and F are sampled only on the clock edge that ends a period (or the first edge after reset). Changes at other times have no effect on the period in progress.
- R7: The first period after reset uses the M, A and F present at the first clock edge with reset high.
- R8: When A + c equals M, `mod_hi` is high for the whole period. With A = 0 and F = 0, `mod_hi` is never high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_val | input | M_W (9) | Main count M |
| a_val | input | P_LOG2 (5) | Swallow count A |
| f_val | input | FRAC_W (5) | Fraction numerator F over 32 |
| mod_hi | output | 1 | High: request modulus P+1 from the prescaler |
| div_pulse | output | 1 | One-cycle pulse at the last cycle of each period |

## Verification
The hardest case to reach from the ports is a period whose swallow count equals M. There, the move out of `ST_SWALLOW` and the period boundary fall on the same cycle. It needs A = M − 1 together with an accumulator carry, and the carry depends on the history of earlier periods. The bench gets there by holding M = 6, A = 5 and F = 30 for 32 periods, which forces 30 full-swallow periods. It also runs a reset in the middle of operation so that the accumulator restart is visible. For the boundary rule, the bench rewrites M, A and F on the second cycle of a period and restores them before the boundary. It then checks that neither the running period nor the next one sees the change.

// File: rtl/fracn_div_pkg.sv
package fracn_div_pkg;

    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } div_state_e;

endpackage

// File: rtl/fracn_frac_accum.sv
// Modulo-2^FRAC_W phase accumulator; carry_o is the overflow of the pending step.
module fracn_frac_accum #(
    parameter int FRAC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac_in,
    output logic              carry_o
);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, frac_in};
        carry_o = sum[FRAC_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= sum[FRAC_W-1:0];
        end
    end

endmodule

// File: rtl/fracn_period_cnt.sv
// Counts prescaler cycles within one division period.
module fracn_period_cnt #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        cnt_o  = cnt_q;
        last_o = (cnt_q == (limit - CNT_W'(1)));
    end

endmodule

// File: rtl/fracn_cfg_hold.sv
// Holds the main count and the per-period swallow count between boundaries.
module fracn_cfg_hold #(
    parameter int M_W = 9,
    parameter int S_W = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [M_W-1:0] m_in,
    input  logic [S_W-1:0] s_in,
    output logic [M_W-1:0] m_q,
    output logic [S_W-1:0] s_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
            s_q <= '0;
        end else if (load) begin
            m_q <= m_in;
            s_q <= s_in;
        end
    end

endmodule

// File: rtl/fracn_swallow_div.sv
module fracn_swallow_div
    import fracn_div_pkg::*;
#(
    parameter int P_LOG2 = 5,
    parameter int M_W    = 9,
    parameter int FRAC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [M_W-1:0]    m_val,
    input  logic [P_LOG2-1:0] a_val,
    input  logic [FRAC_W-1:0] f_val,
    output logic              mod_hi,
    output logic              div_pulse
);

    localparam int S_W   = P_LOG2 + 1;
    localparam int CMP_W = M_W + 1;

    div_state_e     state, nxt;
    logic           load;
    logic           carry;
    logic [S_W-1:0] s_new;
    logic [M_W-1:0] m_q;
    logic [S_W-1:0] s_q;
    logic [M_W-1:0] cnt;
    logic           last;
    logic           in_load;
    logic           swallow_end;
    logic           s_new_nz;

    fracn_frac_accum #(.FRAC_W(FRAC_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (load),
        .frac_in (f_val),
        .carry_o (carry)
    );

    fracn_cfg_hold #(.M_W(M_W), .S_W(S_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .m_in  (m_val),
        .s_in  (s_new),
        .m_q   (m_q),
        .s_q   (s_q)
    );

    fracn_period_cnt #(.CNT_W(M_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (load),
        .limit  (m_q),
        .cnt_o  (cnt),
        .last_o (last)
    );

    always_comb begin
        s_new       = S_W'(a_val) + S_W'(carry);
        s_new_nz    = (s_new != '0);
        swallow_end = ((CMP_W'(cnt) + CMP_W'(1)) == CMP_W'(s_q));
        in_load     = (state == ST_LOAD);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LOAD;
        end else begin
            state <= nxt;
        end
    end

    // Next state and boundary load
    always_comb begin
        nxt  = state;
        load = 1'b0;
        unique case (state)
            ST_LOAD: begin
                load = 1'b1;
                nxt  = s_new_nz ? ST_SWALLOW : ST_MAIN;
            end
            ST_SWALLOW: begin
                if (last) begin
                    load = 1'b1;
                    nxt  = s_new_nz ? ST_SWALLOW : ST_MAIN;
                end else if (swallow_end) begin
                    nxt = ST_MAIN;
                end
            end
            ST_MAIN: begin
                if (last) begin
                    load = 1'b1;
                    nxt  = s_new_nz ? ST_SWALLOW : ST_MAIN;
                end
            end
            default: begin
                nxt  = ST_LOAD;
                load = 1'b0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        mod_hi    = (state == ST_SWALLOW);
        div_pulse = last && (state != ST_LOAD);
    end

endmodule

// File: rtl/fracn_div_chk.sv
module fracn_div_chk #(
    parameter int M_W = 9,
    parameter int S_W = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mod_hi,
    input logic           div_pulse,
    input logic           in_load,
    input logic [M_W-1:0] m_q,
    input logic [S_W-1:0] s_q
);

    localparam int H_W = M_W + 1;

    logic [H_W-1:0] hi_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_seen <= '0;
        end else if (div_pulse || in_load) begin
            hi_seen <= '0;
        end else if (mod_hi) begin
            hi_seen <= hi_seen + H_W'(1);
        end
    end

    p_quiet_in_reset_r1: assert property (@(posedge clk)
        !rst_n |-> (!mod_hi && !div_pulse));

    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    p_hi_starts_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_hi) |-> ($past(div_pulse) || $past(in_load)));

    p_hi_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> ((hi_seen + H_W'(mod_hi)) == H_W'(s_q)));

    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(div_pulse) || $past(in_load)) |-> ($stable(m_q) && $stable(s_q)));

    p_swallow_fits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_load |-> (H_W'(s_q) <= H_W'(m_q)));

endmodule

bind fracn_swallow_div fracn_div_chk #(.M_W(M_W), .S_W(S_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_hi    (mod_hi),
    .div_pulse (div_pulse),
    .in_load   (in_load),
    .m_q       (m_q),
    .s_q       (s_q)
);

// File: tb/tb_fracn_swallow_div.sv
module tb_fracn_swallow_div;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 180000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] m_val = 9'd9;
    logic [4:0] a_val = 5'd3;
    logic [4:0] f_val = 5'd16;
    logic       mod_hi;
    logic       div_pulse;

    fracn_swallow_div dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .m_val     (m_val),
        .a_val     (a_val),
        .f_val     (f_val),
        .mod_hi    (mod_hi),
        .div_pulse (div_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_exp, s_exp, acc_m, k, hi_cnt;
    bit order_bad, load_pending, saw_pulse;
    int carry_sum, hi_total, full_periods, last_len, last_hi;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        int s;
        if (load_pending) begin
            m_exp = int'(m_val);
            s = acc_m + int'(f_val);
            acc_m = s % 32;
            s_exp = int'(a_val) + ((s >= 32) ? 1 : 0);
            carry_sum += (s >= 32) ? 1 : 0;
            load_pending = 0;
            k = 0;
            hi_cnt = 0;
            order_bad = 0;
        end
        @(negedge clk);
        saw_pulse = 0;
        if (mod_hi !== (k < s_exp)) order_bad = 1;
        if (mod_hi === 1'b1) begin
            hi_cnt++;
            hi_total++;
        end
        if (div_pulse === 1'b1) begin
            check(k + 1 == m_exp, "R2 period length", k + 1, m_exp);
            check(hi_cnt == s_exp, "R3 swallow cycles", hi_cnt, s_exp);
            check(!order_bad, "R3 swallow prefix order", int'(order_bad), 0);
            if (hi_cnt == k + 1) full_periods++;
            last_len = k + 1;
            last_hi = hi_cnt;
            load_pending = 1;
            saw_pulse = 1;
        end else begin
            k++;
        end
    endtask

    task automatic run_periods(input int m, input int a, input int f, input int n);
        for (int i = 0; i < n; i++) begin
            m_val = 9'(m);
            a_val = 5'(a);
            f_val = 5'(f);
            do tick(); while (!saw_pulse);
        end
    endtask

    // change inputs on the second cycle, restore them before the boundary (R6)
    task automatic run_mid(input int m, input int a, input int f);
        int ref_m, ref_s;
        m_val = 9'(m);
        a_val = 5'(a);
        f_val = 5'(f);
        tick();
        ref_m = m_exp;
        ref_s = s_exp;
        m_val = 9'(m + 3);
        a_val = 5'(a + 1);
        f_val = 5'(30 - f);
        tick();
        m_val = 9'(m);
        a_val = 5'(a);
        f_val = 5'(f);
        do tick(); while (!saw_pulse);
        check(last_len == ref_m, "R6 mid-period change ignored (length)", last_len, ref_m);
        check(last_hi == ref_s, "R6 mid-period change ignored (swallow)", last_hi, ref_s);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(mod_hi === 1'b0, "R1 mod_hi low in reset", int'(mod_hi), 0);
            check(div_pulse === 1'b0, "R1 div_pulse low in reset", int'(div_pulse), 0);
        end
        m_val = 9'd9;
        a_val = 5'd3;
        f_val = 5'd16;
        acc_m = 0;
        load_pending = 1;
        k = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        s_exp = 0;
        m_exp = 0;
        do_reset();
        // R7 and R1: first period uses the config at release, no carry yet
        do tick(); while (!saw_pulse);
        check(last_len == 9, "R7 first period length", last_len, 9);
        check(last_hi == 3, "R1 accumulator cleared by reset", last_hi, 3);
        run_periods(9, 3, 16, 1);
        check(last_hi == 4, "R1 carry on second period", last_hi, 4);

        // R2/R3 sweep over small M and every legal A
        for (int m = 4; m <= 14; m++)
            for (int a = 0; a < m; a++)
                run_periods(m, a, 0, 1);

        // R4: every F, 32 periods each
        for (int f = 0; f <= 30; f++) begin
            carry_sum = 0;
            run_periods(40, 7, f, 32);
            check(carry_sum == f, "R4 extra cycles over 32 periods", carry_sum, f);
        end

        // R5: shorter repetition for even F
        carry_sum = 0; run_periods(12, 2, 16, 2);
        check(carry_sum == 1, "R5 F=16 over 2 periods", carry_sum, 1);
        carry_sum = 0; run_periods(12, 2, 8, 4);
        check(carry_sum == 1, "R5 F=8 over 4 periods", carry_sum, 1);
        carry_sum = 0; run_periods(12, 2, 24, 4);
        check(carry_sum == 3, "R5 F=24 over 4 periods", carry_sum, 3);
        carry_sum = 0; run_periods(12, 2, 12, 8);
        check(carry_sum == 3, "R5 F=12 over 8 periods", carry_sum, 3);

        // R6: mid-period changes
        run_mid(10, 4, 5);
        run_mid(20, 0, 17);
        run_mid(7, 6, 30);

        // R8: swallow equal to M, and no swallow at all
        full_periods = 0;
        run_periods(6, 5, 30, 32);
        check(full_periods == 30, "R8 full-swallow periods", full_periods, 30);
        hi_total = 0;
        run_periods(8, 0, 0, 6);
        check(hi_total == 0, "R8 A=0 F=0 never swallows", hi_total, 0);

        // upper end of M
        run_periods(510, 30, 29, 3);

        // reset in the middle of a period, then R7/R1 again
        repeat (3) tick();
        do_reset();
        do tick(); while (!saw_pulse);
        check(last_len == 9, "R7 first period after mid-run reset", last_len, 9);
        check(last_hi == 3, "R1 accumulator cleared after mid-run reset", last_hi, 3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule